// File: doc/BRIEF.md
# Conditional Skip Evaluation Unit

This unit settles whether the instruction after the current one is stepped over. It takes a 16-bit instruction word with a valid strobe. It also takes the program counter value that normal sequencing would produce, two read ports into an external sixteen-entry 8-bit register file, and a 16-bit vector of key states. It handles three kinds of comparison. The first compares a register with the low byte of the instruction. The second compares two registers. The third looks up a key, using a register value as the key number. The unit returns a skip decision, the next program counter and an illegal-encoding flag.

The register file itself is outside the unit. The unit drives the two register numbers taken from the instruction, and expects the read data back in the same cycle. All results are captured on the clock edge where the strobe is high. The skip, illegal and result-valid outputs stay high for exactly one cycle. The next program counter holds its value until the next strobe. Instruction words whose top nibble selects some other class pass through: no skip and no illegal flag.

Top module: `cond_skip_unit`

## Requirements
- R1: With top nibble 0x3, a skip happens exactly when the register numbered by bits 11:8 equals bits 7:0 of the instruction.
- R2: With top nibble 0x4, a skip happens exactly when that register differs from bits 7:0.
- R3: With top nibble 0x5 and bits 3:0 zero, a skip happens when the registers numbered by bits 11:8 and bits 7:4 hold equal values. With bits 3:0 non-zero, the illegal flag is raised and no skip happens.
- R4: With top nibble 0x9 and bits 3:0 zero, a skip happens when those two registers differ. With bits 3:0 non-zero, the illegal flag is raised and no skip happens.
- R5: With top nibble 0xE and low byte 0x9E, a skip happens when the key bit `keys_i[k]` is 1. Here k is the low 4 bits of the register numbered by bits 11:8; its upper bits are ignored.
- R6: With top nibble 0xE and low byte 0xA1, a skip happens when key bit k, chosen as in R5, is 0.
- R7: With top nibble 0xE and any other low byte, the illegal flag is raised and no skip happens.
- R8: On a skip, the next PC is the normal-advance PC plus 2, modulo 2^PC_W.
- R9: Without a skip, the next PC equals the normal-advance PC.
- R10: The results appear in the cycle after a strobed edge. In that cycle the result-valid output is high. The skip, illegal and result-valid outputs are high for one cycle only. The next PC keeps its value through every cycle without a strobe.
- R11: Any other top nibble gives no skip and no illegal flag.
- R12: After reset, the skip, illegal and result-valid outputs are 0 and the next PC is 0.
- R13: The register address outputs always carry bits 11:8 (X) and bits 7:4 (Y) of the instruction input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction strobe |
| instr_i | input | 16 | Instruction word |
| pc_adv_i | input | PC_W | Program counter after normal advance |
| reg_x_addr_o | output | 4 | Register file read address, X field |
| reg_y_addr_o | output | 4 | Register file read address, Y field |
| reg_x_data_i | input | 8 | Read data for X |
| reg_y_data_i | input | 8 | Read data for Y |
| keys_i | input | NUM_KEYS | Key states, 1 = pressed |
| res_valid_o | output | 1 | One-cycle result strobe |
| skip_o | output | 1 | One-cycle skip decision |
| illegal_o | output | 1 | One-cycle illegal-encoding flag |
| pc_next_o | output | PC_W | Next program counter, held between strobes |

## Verification
The hardest case to reach is a key lookup in which the register value has non-zero upper bits. The bench loads a register with a value above 15 whose low nibble names a pressed key. It then issues both key forms and checks that only the low nibble chose the key. A second case that is hard to reach is the PC wrapping on a skip. The bench reaches it by presenting normal-advance values at the top of the address range. Illegal low nibbles are driven with register contents that would otherwise cause a skip. This shows that the illegal flag overrides the comparison.

// File: rtl/skip_pkg.sv
package skip_pkg;
    localparam int DATA_W = 8;
    localparam int REG_AW = 4;
    localparam int INSTR_W = 16;

    localparam logic [3:0] CLS_EQ_IMM = 4'h3;
    localparam logic [3:0] CLS_NE_IMM = 4'h4;
    localparam logic [3:0] CLS_EQ_REG = 4'h5;
    localparam logic [3:0] CLS_NE_REG = 4'h9;
    localparam logic [3:0] CLS_KEY    = 4'hE;
    localparam logic [7:0] SUB_KEY_DN = 8'h9E;
    localparam logic [7:0] SUB_KEY_UP = 8'hA1;

    typedef enum logic [2:0] {
        CMP_NONE,
        CMP_EQ_IMM,
        CMP_NE_IMM,
        CMP_EQ_REG,
        CMP_NE_REG,
        CMP_KEY_DN,
        CMP_KEY_UP
    } cmp_kind_e;
endpackage

// File: rtl/skip_decode.sv
module skip_decode
    import skip_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output cmp_kind_e          kind_o,
    output logic               illegal_o,
    output logic [REG_AW-1:0]  x_idx_o,
    output logic [REG_AW-1:0]  y_idx_o,
    output logic [DATA_W-1:0]  imm_o
);
    logic [3:0] cls;
    logic [3:0] sub_nib;
    logic [7:0] sub_byte;

    assign cls      = instr_i[15:12];
    assign sub_nib  = instr_i[3:0];
    assign sub_byte = instr_i[7:0];
    assign x_idx_o  = instr_i[11:8];
    assign y_idx_o  = instr_i[7:4];
    assign imm_o    = instr_i[7:0];

    always_comb begin
        kind_o    = CMP_NONE;
        illegal_o = 1'b0;
        unique case (cls)
            CLS_EQ_IMM: kind_o = CMP_EQ_IMM;
            CLS_NE_IMM: kind_o = CMP_NE_IMM;
            CLS_EQ_REG: begin
                if (sub_nib == 4'h0) kind_o = CMP_EQ_REG;
                else                 illegal_o = 1'b1;
            end
            CLS_NE_REG: begin
                if (sub_nib == 4'h0) kind_o = CMP_NE_REG;
                else                 illegal_o = 1'b1;
            end
            CLS_KEY: begin
                if (sub_byte == SUB_KEY_DN)      kind_o = CMP_KEY_DN;
                else if (sub_byte == SUB_KEY_UP) kind_o = CMP_KEY_UP;
                else                             illegal_o = 1'b1;
            end
            default: kind_o = CMP_NONE;
        endcase
    end
endmodule

// File: rtl/skip_compare.sv
module skip_compare
    import skip_pkg::*;
#(
    parameter int NUM_KEYS = 16
) (
    input  cmp_kind_e         kind_i,
    input  logic [DATA_W-1:0] vx_i,
    input  logic [DATA_W-1:0] vy_i,
    input  logic [DATA_W-1:0] imm_i,
    input  logic [NUM_KEYS-1:0] keys_i,
    output logic              take_o
);
    localparam int KEY_W = $clog2(NUM_KEYS);

    logic eq_imm;
    logic eq_reg;
    logic key_dn;

    assign eq_imm = (vx_i == imm_i);
    assign eq_reg = (vx_i == vy_i);
    assign key_dn = keys_i[vx_i[KEY_W-1:0]];

    always_comb begin
        unique case (kind_i)
            CMP_EQ_IMM: take_o = eq_imm;
            CMP_NE_IMM: take_o = !eq_imm;
            CMP_EQ_REG: take_o = eq_reg;
            CMP_NE_REG: take_o = !eq_reg;
            CMP_KEY_DN: take_o = key_dn;
            CMP_KEY_UP: take_o = !key_dn;
            default:    take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cond_skip_unit.sv
module cond_skip_unit
    import skip_pkg::*;
#(
    parameter int PC_W     = 12,
    parameter int NUM_KEYS = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                in_valid_i,
    input  logic [15:0]         instr_i,
    input  logic [PC_W-1:0]     pc_adv_i,
    output logic [3:0]          reg_x_addr_o,
    output logic [3:0]          reg_y_addr_o,
    input  logic [7:0]          reg_x_data_i,
    input  logic [7:0]          reg_y_data_i,
    input  logic [NUM_KEYS-1:0] keys_i,
    output logic                res_valid_o,
    output logic                skip_o,
    output logic                illegal_o,
    output logic [PC_W-1:0]     pc_next_o
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(2);

    typedef struct packed {
        logic            vld;
        logic            skip;
        logic            ill;
        logic [PC_W-1:0] pc;
    } res_t;

    cmp_kind_e         kind;
    logic              dec_ill;
    logic              take;
    logic [DATA_W-1:0] imm;
    res_t              res_d, res_q;

    skip_decode u_dec (
        .instr_i   (instr_i),
        .kind_o    (kind),
        .illegal_o (dec_ill),
        .x_idx_o   (reg_x_addr_o),
        .y_idx_o   (reg_y_addr_o),
        .imm_o     (imm)
    );

    skip_compare #(.NUM_KEYS(NUM_KEYS)) u_cmp (
        .kind_i (kind),
        .vx_i   (reg_x_data_i),
        .vy_i   (reg_y_data_i),
        .imm_i  (imm),
        .keys_i (keys_i),
        .take_o (take)
    );

    always_comb begin
        res_d      = res_q;
        res_d.vld  = 1'b0;
        res_d.skip = 1'b0;
        res_d.ill  = 1'b0;
        if (in_valid_i) begin
            res_d.vld  = 1'b1;
            res_d.skip = take;
            res_d.ill  = dec_ill;
            res_d.pc   = take ? (pc_adv_i + PC_STEP) : pc_adv_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
    end

    assign res_valid_o = res_q.vld;
    assign skip_o      = res_q.skip;
    assign illegal_o   = res_q.ill;
    assign pc_next_o   = res_q.pc;
endmodule

// File: rtl/cond_skip_checker.sv
module cond_skip_checker #(
    parameter int PC_W     = 12,
    parameter int NUM_KEYS = 16
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                in_valid_i,
    input logic [15:0]         instr_i,
    input logic [PC_W-1:0]     pc_adv_i,
    input logic [7:0]          reg_x_data_i,
    input logic [NUM_KEYS-1:0] keys_i,
    input logic                res_valid_o,
    input logic                skip_o,
    input logic                illegal_o,
    input logic [PC_W-1:0]     pc_next_o
);
    localparam int KEY_W = $clog2(NUM_KEYS);

    assert_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> res_valid_o);

    assert_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> (!res_valid_o && !skip_o && !illegal_o));

    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> $stable(pc_next_o));

    assert_skip_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> (!skip_o || pc_next_o == PC_W'($past(pc_adv_i) + PC_W'(2))));

    assert_pass_pc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> (skip_o || pc_next_o == $past(pc_adv_i)));

    assert_ill_noskip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> !skip_o);

    assert_imm_eq_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && instr_i[15:12] == 4'h3)
        |=> (skip_o == ($past(reg_x_data_i) == $past(instr_i[7:0]))));

    assert_key_dn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && instr_i == {4'hE, instr_i[11:8], 8'h9E})
        |=> (skip_o == $past(keys_i[reg_x_data_i[KEY_W-1:0]])));

    assert_other_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && !(instr_i[15:12] inside {4'h3, 4'h4, 4'h5, 4'h9, 4'hE}))
        |=> (!skip_o && !illegal_o));
endmodule

bind cond_skip_unit cond_skip_checker #(.PC_W(PC_W), .NUM_KEYS(NUM_KEYS)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .instr_i      (instr_i),
    .pc_adv_i     (pc_adv_i),
    .reg_x_data_i (reg_x_data_i),
    .keys_i       (keys_i),
    .res_valid_o  (res_valid_o),
    .skip_o       (skip_o),
    .illegal_o    (illegal_o),
    .pc_next_o    (pc_next_o)
);

// File: tb/tb_cond_skip_unit.sv
`timescale 1ns/1ps
module tb_cond_skip_unit;
    localparam int PC_W = 12;
    localparam int NUM_KEYS = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [15:0]         instr = '0;
    logic [PC_W-1:0]     pc_adv = '0;
    logic [3:0]          x_addr, y_addr;
    logic [7:0]          x_data, y_data;
    logic [NUM_KEYS-1:0] keys = '0;
    logic                res_valid, skip, illegal;
    logic [PC_W-1:0]     pc_next;
    logic [7:0]          rf [16];

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign x_data = rf[x_addr];
    assign y_data = rf[y_addr];

    cond_skip_unit #(.PC_W(PC_W), .NUM_KEYS(NUM_KEYS)) dut (
        .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .instr_i(instr),
        .pc_adv_i(pc_adv), .reg_x_addr_o(x_addr), .reg_y_addr_o(y_addr),
        .reg_x_data_i(x_data), .reg_y_data_i(y_data), .keys_i(keys),
        .res_valid_o(res_valid), .skip_o(skip), .illegal_o(illegal),
        .pc_next_o(pc_next)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one instruction, then check the registered result one edge later.
    task automatic issue(string req, logic [15:0] iw, logic [PC_W-1:0] pc,
                         logic exp_skip, logic exp_ill);
        logic [PC_W-1:0] exp_pc;
        exp_pc = exp_skip ? PC_W'(pc + 2) : pc;
        @(negedge clk);
        instr = iw; pc_adv = pc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "valid", {31'd0, res_valid}, 32'd1);
        chk(req, "skip", {31'd0, skip}, {31'd0, exp_skip});
        chk(req, "illegal", {31'd0, illegal}, {31'd0, exp_ill});
        chk(req, "pc", {20'd0, pc_next}, {20'd0, exp_pc});
    endtask

    task automatic t_reset();
        chk("R12", "valid", {31'd0, res_valid}, 32'd0);
        chk("R12", "skip", {31'd0, skip}, 32'd0);
        chk("R12", "illegal", {31'd0, illegal}, 32'd0);
        chk("R12", "pc", {20'd0, pc_next}, 32'd0);
    endtask

    task automatic t_imm();
        rf[4'h2] = 8'h5A;
        issue("R1", 16'h325A, 12'h200, 1'b1, 1'b0);
        issue("R1", 16'h325B, 12'h202, 1'b0, 1'b0);
        issue("R2", 16'h425A, 12'h204, 1'b0, 1'b0);
        issue("R2", 16'h4200, 12'h206, 1'b1, 1'b0);
    endtask

    task automatic t_reg();
        rf[4'h3] = 8'h77; rf[4'h7] = 8'h77; rf[4'h8] = 8'h76;
        @(negedge clk);
        instr = 16'h5370;
        #1;
        chk("R13", "x_addr", {28'd0, x_addr}, 32'h3);
        chk("R13", "y_addr", {28'd0, y_addr}, 32'h7);
        issue("R3", 16'h5370, 12'h300, 1'b1, 1'b0);
        issue("R3", 16'h5380, 12'h302, 1'b0, 1'b0);
        issue("R4", 16'h9380, 12'h304, 1'b1, 1'b0);
        issue("R4", 16'h9370, 12'h306, 1'b0, 1'b0);
    endtask

    task automatic t_key();
        rf[4'hA] = 8'h13;     // low nibble 3; upper bits must be ignored
        rf[4'hB] = 8'h05;
        keys = 16'h0008;      // only key 3 pressed
        issue("R5", 16'hEA9E, 12'h400, 1'b1, 1'b0);
        issue("R5", 16'hEB9E, 12'h402, 1'b0, 1'b0);
        issue("R6", 16'hEAA1, 12'h404, 1'b0, 1'b0);
        issue("R6", 16'hEBA1, 12'h406, 1'b1, 1'b0);
    endtask

    task automatic t_illegal();
        rf[4'h3] = 8'h77; rf[4'h7] = 8'h77; rf[4'h8] = 8'h76;
        issue("R3", 16'h5371, 12'h500, 1'b0, 1'b1);
        issue("R4", 16'h938F, 12'h502, 1'b0, 1'b1);
        issue("R7", 16'hEA9F, 12'h504, 1'b0, 1'b1);
        issue("R7", 16'hEA00, 12'h506, 1'b0, 1'b1);
    endtask

    task automatic t_wrap();
        rf[4'h1] = 8'h10;
        issue("R8", 16'h3110, 12'hFFE, 1'b1, 1'b0);
        issue("R8", 16'h3110, 12'hFFF, 1'b1, 1'b0);
        issue("R9", 16'h3111, 12'hFFF, 1'b0, 1'b0);
    endtask

    task automatic t_other();
        rf[4'h1] = 8'h10;
        issue("R11", 16'h1110, 12'h600, 1'b0, 1'b0);
        issue("R11", 16'h8110, 12'h602, 1'b0, 1'b0);
        issue("R11", 16'hF10A, 12'h604, 1'b0, 1'b0);
    endtask

    task automatic t_hold();
        rf[4'h1] = 8'h10;
        issue("R10", 16'h3110, 12'h700, 1'b1, 1'b0);
        instr = 16'h3111; pc_adv = 12'h123;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10", "valid low", {31'd0, res_valid}, 32'd0);
            chk("R10", "skip low", {31'd0, skip}, 32'd0);
            chk("R10", "illegal low", {31'd0, illegal}, 32'd0);
            chk("R10", "pc held", {20'd0, pc_next}, 32'h702);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 8'h00;
        #1;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_imm();
        t_reg();
        t_key();
        t_illegal();
        t_wrap();
        t_other();
        t_hold();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule